// File: doc/BRIEF.md
# Next Fetch Address Unit Without a Target Buffer

The block selects the next instruction fetch address in every cycle without any target buffer lookup. The instruction cache supplies a small predecode code stored with each word. That code says whether the fetched word is a conditional branch, a direct jump, a call, a return, an indirect jump or anything else. The fetch stage presents the current PC, the predecode code, the displacement field of the fetched word and an indirect target that was read elsewhere. One cycle later the block returns the chosen address.

A direct target needs no adder. The displacement field replaces PC bits [22:2], the two low bits become zero, and the upper PC bits pass through unchanged, so a direct branch stays inside its aligned 8 MB segment. The only adder forms PC + 4. Conditional branch direction comes from a table of 2-bit counters indexed by one global history register. Returns pop a circular return stack that calls fill. The history index used for each prediction is reported with the prediction. A resolve port later shifts the real outcome into the history and trains the counter at that reported index.

Top module: `nfa_unit`

## Requirements
- R1: During reset and in the first cycle after it, `nxt_vld`, `pred_taken`, `nxt_pc` and `pred_idx` are zero. Reset sets every counter to 1 (weakly not taken), clears the history and empties the return stack.
- R2: Outputs are registered. `nxt_vld` equals `fetch_vld` of the previous cycle. When `fetch_vld` is low, `nxt_pc`, `pred_taken` and `pred_idx` keep their values.
- R3: Kind codes 0, 6 and 7 (other) give `nxt_pc = fetch_pc + 4`.
- R4: Kind 2 (direct jump) and kind 3 (call) always give the spliced target `{fetch_pc[31:23], fetch_disp, 2'b00}` and report `pred_taken = 0`. For every kind other than 1, `pred_taken` is 0.
- R5: Kind 1 (conditional branch) reads the counter indexed by the current history. A value of 2 or 3 gives the spliced target with `pred_taken = 1`. A value of 0 or 1 gives `fetch_pc + 4` with `pred_taken = 0`. `pred_idx` reports the history value that was used.
- R6: A cycle with `res_vld` high shifts `res_taken` into the history at bit 0 (older bits move up). It also moves the counter at `res_idx` up by 1 when taken and down by 1 when not taken, saturating at 3 and at 0.
- R7: A call (kind 3) pushes `fetch_pc + 4`. A return (kind 4) pops the most recent entry and uses it as `nxt_pc`.
- R8: The return stack holds 8 entries. A push onto a full stack overwrites the oldest entry, so at most the 8 most recent return addresses can be popped.
- R9: A return on an empty stack gives `fetch_pc + 4`.
- R10: Kind 5 (indirect jump) gives `nxt_pc = ind_target`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld | input | 1 | A fetched word is present this cycle |
| fetch_pc | input | 32 | Address of the fetched word |
| fetch_kind | input | 3 | Predecode code from the instruction cache |
| fetch_disp | input | 21 | Word displacement field of the fetched word |
| ind_target | input | 32 | Register target for indirect jumps |
| res_vld | input | 1 | A conditional branch has resolved |
| res_taken | input | 1 | Actual outcome of the resolved branch |
| res_idx | input | 10 | Counter index that was reported with its prediction |
| nxt_vld | output | 1 | `nxt_pc` was produced for the previous fetch |
| nxt_pc | output | 32 | Next fetch address |
| pred_taken | output | 1 | The conditional branch was predicted taken |
| pred_idx | output | 10 | History value used for the prediction |

## Verification
The assertions take for granted that `fetch_kind` always carries a defined code and that `fetch_vld` and `res_vld` are never unknown once reset ends. They also assume that each fetch stands alone, so no property depends on the order of fetches. The bench drives every input at the falling edge from a single task per scenario. It holds `fetch_vld` high for exactly one cycle per fetch, drives only `res_idx` values that the block itself reported, and never raises fetch and resolve in the same cycle.

// File: rtl/nfa_pkg.sv
package nfa_pkg;
  // Predecode codes stored next to every instruction cache word.
  typedef enum logic [2:0] {
    K_OTHER = 3'd0,
    K_COND  = 3'd1,
    K_JUMP  = 3'd2,
    K_CALL  = 3'd3,
    K_RET   = 3'd4,
    K_IND   = 3'd5
  } fetch_kind_e;

  localparam logic [1:0] CTR_INIT = 2'b01;
  localparam logic [1:0] CTR_MAX  = 2'b11;
  localparam logic [1:0] CTR_MIN  = 2'b00;
endpackage

// File: rtl/nfa_pht.sv
// Global history register plus a table of 2-bit saturating counters.
module nfa_pht
  import nfa_pkg::*;
#(
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  output logic [HIST_W-1:0] hist,
  output logic              taken,
  input  logic              upd_vld,
  input  logic              upd_taken,
  input  logic [HIST_W-1:0] upd_idx
);
  localparam int PHT_N = 1 << HIST_W;

  logic [1:0]        ctr [PHT_N];
  logic [HIST_W-1:0] ghr;
  logic [1:0]        cur;

  assign cur = ctr[upd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PHT_N; i++) ctr[i] <= CTR_INIT;
    end else if (upd_vld) begin
      if (upd_taken && cur != CTR_MAX)       ctr[upd_idx] <= cur + 2'd1;
      else if (!upd_taken && cur != CTR_MIN) ctr[upd_idx] <= cur - 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ghr <= '0;
    else if (upd_vld) ghr <= {ghr[HIST_W-2:0], upd_taken};
  end

  assign hist  = ghr;
  assign taken = ctr[ghr][1];
endmodule

// File: rtl/nfa_ras.sv
// Circular return stack: overflow overwrites the oldest entry,
// and a pop on an empty stack hands back the fallback address.
module nfa_ras #(
  parameter int AW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  input  logic [AW-1:0] fallback,
  output logic [AW-1:0] top_addr
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] wp;
  logic [PW-1:0] wp_dec;
  logic [CW-1:0] fill;
  logic          empty;

  assign wp_dec   = wp - PW'(1);
  assign empty    = (fill == '0);
  assign top_addr = empty ? fallback : mem[wp_dec];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      fill <= '0;
    end else if (push) begin
      wp <= wp + PW'(1);
      if (fill != CW'(DEPTH)) fill <= fill + CW'(1);
    end else if (pop && !empty) begin
      wp   <= wp_dec;
      fill <= fill - CW'(1);
    end
  end
endmodule

// File: rtl/nfa_unit.sv
module nfa_unit
  import nfa_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DISP_W    = 21,
  parameter int HIST_W    = 10,
  parameter int RAS_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_vld,
  input  logic [AW-1:0]     fetch_pc,
  input  logic [2:0]        fetch_kind,
  input  logic [DISP_W-1:0] fetch_disp,
  input  logic [AW-1:0]     ind_target,
  input  logic              res_vld,
  input  logic              res_taken,
  input  logic [HIST_W-1:0] res_idx,
  output logic              nxt_vld,
  output logic [AW-1:0]     nxt_pc,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_idx
);
  localparam int SEG_LO = DISP_W + 2;

  logic [AW-1:0]     fall, splice, ras_out, nxt_d;
  logic [HIST_W-1:0] ghr;
  logic              pht_taken;
  logic              is_cond, is_jmp, is_call, is_ret, is_ind;
  logic              sel_tgt;

  // Only adder in the path: the fall-through address.
  assign fall   = fetch_pc + AW'(4);
  // Direct target: displacement replaces the in-segment word bits.
  assign splice = {fetch_pc[AW-1:SEG_LO], fetch_disp, 2'b00};

  assign is_cond = (fetch_kind == K_COND);
  assign is_jmp  = (fetch_kind == K_JUMP);
  assign is_call = (fetch_kind == K_CALL);
  assign is_ret  = (fetch_kind == K_RET);
  assign is_ind  = (fetch_kind == K_IND);
  assign sel_tgt = is_jmp | is_call | (is_cond & pht_taken);

  nfa_pht #(.HIST_W(HIST_W)) u_pht (
    .clk       (clk),
    .rst       (rst),
    .hist      (ghr),
    .taken     (pht_taken),
    .upd_vld   (res_vld),
    .upd_taken (res_taken),
    .upd_idx   (res_idx)
  );

  nfa_ras #(.AW(AW), .DEPTH(RAS_DEPTH)) u_ras (
    .clk       (clk),
    .rst       (rst),
    .push      (fetch_vld & is_call),
    .push_addr (fall),
    .pop       (fetch_vld & is_ret),
    .fallback  (fall),
    .top_addr  (ras_out)
  );

  // Single select level in front of one output multiplexer.
  always_comb begin
    nxt_d = fall;
    if (sel_tgt) nxt_d = splice;
    if (is_ret)  nxt_d = ras_out;
    if (is_ind)  nxt_d = ind_target;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_vld    <= 1'b0;
      nxt_pc     <= '0;
      pred_taken <= 1'b0;
      pred_idx   <= '0;
    end else begin
      nxt_vld <= fetch_vld;
      if (fetch_vld) begin
        nxt_pc     <= nxt_d;
        pred_taken <= is_cond & pht_taken;
        pred_idx   <= ghr;
      end
    end
  end
endmodule

// File: rtl/nfa_unit_chk.sv
module nfa_unit_chk #(
  parameter int AW     = 32,
  parameter int DISP_W = 21
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_vld,
  input logic [AW-1:0]     fetch_pc,
  input logic [2:0]        fetch_kind,
  input logic [DISP_W-1:0] fetch_disp,
  input logic [AW-1:0]     ind_target,
  input logic              nxt_vld,
  input logic [AW-1:0]     nxt_pc,
  input logic              pred_taken
);
  localparam int SEG_LO = DISP_W + 2;

  logic other_kind;
  assign other_kind = (fetch_kind == 3'd0) || (fetch_kind == 3'd6) || (fetch_kind == 3'd7);

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!nxt_vld && !pred_taken && nxt_pc == '0));

  assert_vld_follow_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (nxt_vld == $past(fetch_vld)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !fetch_vld |=> ($stable(nxt_pc) && $stable(pred_taken)));

  assert_fallthrough_R3: assert property (@(posedge clk) disable iff (rst)
    (fetch_vld && other_kind) |=> (nxt_pc == $past(fetch_pc) + AW'(4)));

  assert_splice_R4: assert property (@(posedge clk) disable iff (rst)
    (fetch_vld && (fetch_kind == 3'd2 || fetch_kind == 3'd3)) |=>
      (nxt_pc[SEG_LO-1:2] == $past(fetch_disp) && nxt_pc[1:0] == 2'b00 &&
       nxt_pc[AW-1:SEG_LO] == $past(fetch_pc[AW-1:SEG_LO])));

  assert_no_pred_R4: assert property (@(posedge clk) disable iff (rst)
    (fetch_vld && fetch_kind != 3'd1) |=> !pred_taken);

  assert_cond_R5: assert property (@(posedge clk) disable iff (rst)
    (fetch_vld && fetch_kind == 3'd1) |=>
      (pred_taken ? (nxt_pc[SEG_LO-1:2] == $past(fetch_disp) &&
                     nxt_pc[AW-1:SEG_LO] == $past(fetch_pc[AW-1:SEG_LO]))
                  : (nxt_pc == $past(fetch_pc) + AW'(4))));

  assert_indirect_R10: assert property (@(posedge clk) disable iff (rst)
    (fetch_vld && fetch_kind == 3'd5) |=> (nxt_pc == $past(ind_target)));
endmodule

bind nfa_unit nfa_unit_chk #(.AW(AW), .DISP_W(DISP_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fetch_vld  (fetch_vld),
  .fetch_pc   (fetch_pc),
  .fetch_kind (fetch_kind),
  .fetch_disp (fetch_disp),
  .ind_target (ind_target),
  .nxt_vld    (nxt_vld),
  .nxt_pc     (nxt_pc),
  .pred_taken (pred_taken)
);

// File: tb/test_nfa_unit.sv
module test_nfa_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_vld = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic [2:0]  fetch_kind = '0;
  logic [20:0] fetch_disp = '0;
  logic [31:0] ind_target = '0;
  logic        res_vld = 1'b0;
  logic        res_taken = 1'b0;
  logic [9:0]  res_idx = '0;
  logic        nxt_vld;
  logic [31:0] nxt_pc;
  logic        pred_taken;
  logic [9:0]  pred_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench-side model built from the requirements.
  int          ctr_m [1024];
  logic [9:0]  ghr_m;
  logic [31:0] ras_m [8];
  int          sp_m, cnt_m;

  always #10 clk = ~clk;

  nfa_unit i_nfa_unit (
    .clk(clk), .rst(rst), .fetch_vld(fetch_vld), .fetch_pc(fetch_pc),
    .fetch_kind(fetch_kind), .fetch_disp(fetch_disp), .ind_target(ind_target),
    .res_vld(res_vld), .res_taken(res_taken), .res_idx(res_idx),
    .nxt_vld(nxt_vld), .nxt_pc(nxt_pc), .pred_taken(pred_taken), .pred_idx(pred_idx)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 1024; i++) ctr_m[i] = 1;
    ghr_m = '0; sp_m = 0; cnt_m = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; fetch_vld = 1'b0; res_vld = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    model_reset();
  endtask

  // One fetch; checks nxt_pc, nxt_vld, pred_taken and (for branches) pred_idx.
  task automatic fetch(input logic [2:0] k, input logic [31:0] pc, input logic [20:0] d,
                       input logic [31:0] ind, input string req);
    logic [31:0] fall, spl, exp;
    bit tk;
    logic [9:0] idx;
    fall = pc + 32'd4;
    spl  = {pc[31:23], d, 2'b00};
    tk = 1'b0; idx = ghr_m;
    case (k)
      3'd1: begin tk = (ctr_m[ghr_m] >= 2); exp = tk ? spl : fall; end
      3'd2: exp = spl;
      3'd3: begin
        exp = spl;
        ras_m[sp_m] = fall; sp_m = (sp_m + 1) % 8;
        if (cnt_m < 8) cnt_m++;
      end
      3'd4: begin
        if (cnt_m > 0) begin sp_m = (sp_m + 7) % 8; exp = ras_m[sp_m]; cnt_m--; end
        else exp = fall;
      end
      3'd5: exp = ind;
      default: exp = fall;
    endcase
    @(negedge clk);
    fetch_vld = 1'b1; fetch_kind = k; fetch_pc = pc; fetch_disp = d; ind_target = ind;
    @(negedge clk);
    fetch_vld = 1'b0;
    chk(nxt_vld === 1'b1, "R2", {31'd0, nxt_vld}, 32'd1);
    chk(nxt_pc === exp, req, nxt_pc, exp);
    chk(pred_taken === tk, req, {31'd0, pred_taken}, {31'd0, tk});
    if (k == 3'd1) chk(pred_idx === idx, "R5", {22'd0, pred_idx}, {22'd0, idx});
  endtask

  task automatic resolve(input bit t, input logic [9:0] idx);
    @(negedge clk);
    res_vld = 1'b1; res_taken = t; res_idx = idx;
    @(negedge clk);
    res_vld = 1'b0;
    if (t && ctr_m[idx] < 3) ctr_m[idx]++;
    else if (!t && ctr_m[idx] > 0) ctr_m[idx]--;
    ghr_m = {ghr_m[8:0], t};
  endtask

  task automatic t_reset();
    chk(nxt_vld === 1'b0 && pred_taken === 1'b0, "R1", {30'd0, nxt_vld, pred_taken}, 32'd0);
    chk(nxt_pc === 32'd0, "R1", nxt_pc, 32'd0);
    chk(pred_idx === 10'd0, "R1", {22'd0, pred_idx}, 32'd0);
    fetch(3'd1, 32'h0000_1000, 21'h00_0040, '0, "R1");  // weakly not taken after reset
    fetch(3'd4, 32'h0000_2000, '0, '0, "R1");           // stack empty after reset
  endtask

  task automatic t_fall();
    fetch(3'd0, 32'h1234_5678, 21'h1F_FFFF, 32'hDEAD_BEEF, "R3");
    fetch(3'd6, 32'hFFFF_FFFC, 21'h0, '0, "R3");
    fetch(3'd7, 32'h0080_0000, 21'h15555, '0, "R3");
  endtask

  task automatic t_hold();
    logic [31:0] keep;
    keep = nxt_pc;
    @(negedge clk);
    chk(nxt_vld === 1'b0, "R2", {31'd0, nxt_vld}, 32'd0);
    chk(nxt_pc === keep, "R2", nxt_pc, keep);
  endtask

  task automatic t_jump();
    fetch(3'd2, 32'hA0FF_FFF0, 21'h00_0003, '0, "R4");
    fetch(3'd2, 32'h007F_FFFC, 21'h1F_FFFF, '0, "R4");
    fetch(3'd2, 32'hFF80_0004, 21'h00_0000, '0, "R4");
  endtask

  task automatic t_ras();
    fetch(3'd3, 32'h0001_0000, 21'h100, '0, "R7");
    fetch(3'd3, 32'h0002_0000, 21'h200, '0, "R7");
    fetch(3'd4, 32'h0000_0500, '0, '0, "R7");
    fetch(3'd4, 32'h0000_0600, '0, '0, "R7");
    fetch(3'd4, 32'h0000_0700, '0, '0, "R9");
    for (int i = 0; i < 10; i++)
      fetch(3'd3, 32'h0100_0000 + 32'(i) * 32'h40, 21'h10, '0, "R8");
    for (int i = 0; i < 9; i++)
      fetch(3'd4, 32'h0200_0000 + 32'(i) * 32'h8, '0, '0, i < 8 ? "R8" : "R9");
  endtask

  task automatic t_pht();
    fetch(3'd1, 32'h0040_0000, 21'h00123, '0, "R5");
    resolve(1'b1, pred_idx);                    // idx 0 -> 2, history 1
    fetch(3'd1, 32'h0040_0010, 21'h00124, '0, "R5");
    resolve(1'b1, 10'd0);                       // idx 0 -> 3
    resolve(1'b1, 10'd0);                       // saturates at 3
    for (int i = 0; i < 12; i++) resolve(1'b0, 10'd5); // history back to 0, idx 5 floors
    fetch(3'd1, 32'h1040_0020, 21'h0ABCD, '0, "R6");   // taken via idx 0 = 3
    resolve(1'b0, 10'd0);                       // 3 -> 2
    for (int i = 0; i < 10; i++) resolve(1'b0, 10'd5);
    fetch(3'd1, 32'h1040_0030, 21'h0ABCE, '0, "R6");   // still taken
    resolve(1'b0, 10'd0);                       // 2 -> 1
    for (int i = 0; i < 10; i++) resolve(1'b0, 10'd5);
    fetch(3'd1, 32'h1040_0040, 21'h0ABCF, '0, "R6");   // not taken
    resolve(1'b1, 10'd5);                       // 0 -> 1 proves floor at 0
    resolve(1'b1, 10'd5);                       // 1 -> 2
    for (int i = 0; i < 8; i++) resolve(1'b0, 10'd9);
    resolve(1'b0, 10'd9);
    resolve(1'b1, 10'd9);
    resolve(1'b0, 10'd9);
    resolve(1'b1, 10'd9);                       // history now 5
    fetch(3'd1, 32'h2000_0100, 21'h1_0000, '0, "R6");  // idx 5 = 2 -> taken
  endtask

  task automatic t_ind();
    fetch(3'd5, 32'h0000_4000, 21'h1FFFF, 32'h8765_4320, "R10");
    fetch(3'd5, 32'hF000_0000, 21'h0, 32'h0000_0004, "R10");
  endtask

  initial begin
    model_reset();
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fall();
    t_hold();
    t_jump();
    t_ind();
    do_reset();
    t_ras();
    do_reset();
    t_pht();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule